// File: doc/BRIEF.md
# SD Card Clock Divider with Command Timeout

This block derives the SD card clock from the core clock with an 11-bit programmable divisor, and runs a 32-bit watchdog counter that other engines start at the beginning of a wait. The divisor input holds the division ratio minus two, so the fastest card clock is half the core clock. The card clock can never be stopped: the slowest setting is the full-scale divisor, and that is also the setting in force from reset until the first period ends.

In data mode the divider normally looks only at the three low divisor bits. A slow-card control bit overrides this so that the full divisor applies at all times. A divisor change is sampled only in the last core cycle of the current card-clock period, so no shortened pulse ever reaches the card. Along with the clock, the block gives a one-core-cycle enable pulse at the card rate. Command and data engines use it, and the timeout counter also decrements on it.

The clock generator is a two-state machine. In PH_HIGH the card clock is high. The transition HIGH_TO_LOW is taken when the high-phase count runs out. In PH_LOW the card clock is low. The transition LOW_TO_HIGH is taken when the low-phase count runs out; it loads the new ratio and raises the enable pulse. The timeout counter is a three-state machine with the states TM_IDLE, TM_RUN and TM_FIRED and these transitions: ARM (any state to TM_RUN on a start strobe), DISARM (TM_RUN to TM_IDLE on a done strobe), EXPIRE (TM_RUN to TM_FIRED on the tick that brings the count to zero) and REARM (TM_FIRED to TM_RUN on a start strobe).

Top module: `sdclk_gen`

## Requirements
- R1: With effective divisor value v, `sd_clk` has a period of exactly v+2 core cycles. A value of 0 gives a period of 2.
- R2: For an odd ratio, the high phase of `sd_clk` is one core cycle longer than the low phase. For an even ratio the two phases are equal.
- R3: While `rst_n` is low, `sd_clk` is 1 and `sd_clk_en` and `tmo_event` are 0. The first period after reset uses the maximum ratio of 2049 core cycles, whatever the divisor input holds.
- R4: A divisor change takes effect only at a period boundary. The inputs present in the last low core cycle set the next period; an earlier change does not alter the period already running.
- R5: When `data_mode`=1 and `slow_card`=0, the effective divisor is `div_val[2:0]` and bits 10:3 are ignored. When `slow_card`=1 or `data_mode`=0, all 11 bits are used.
- R6: `sd_clk_en` is high for exactly one core cycle per period: the first cycle of each high phase.
- R7: A `tmo_start` strobe loads the counter from `tmo_start_val`. Each `sd_clk_en` cycle then decrements it. On the enable that takes the count from 1 (or from 0) to expiry, `tmo_event` pulses for one core cycle in the following cycle, and only once.
- R8: A `tmo_done` strobe stops a running count, and no `tmo_event` follows.
- R9: When `tmo_start` and `tmo_done` arrive in the same cycle, the start wins. When `tmo_done` coincides with the final enable, done wins and no event is raised.
- R10: A `tmo_start` during a running count or after expiry reloads the counter and starts a fresh full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 11 | Divisor value (ratio minus two) |
| slow_card | input | 1 | Forces the full 11-bit divisor in data mode |
| data_mode | input | 1 | 1 while the card is in data-transfer mode |
| tmo_start_val | input | 32 | Timeout reload value in card-clock cycles |
| tmo_start | input | 1 | Strobe: load and start the timeout counter |
| tmo_done | input | 1 | Strobe: the awaited operation finished; stop counting |
| sd_clk | output | 1 | Card clock |
| sd_clk_en | output | 1 | One-cycle pulse at the start of each card-clock high phase |
| tmo_event | output | 1 | One-cycle pulse when the timeout expires |

## Verification
Two collisions in the timeout counter are provoked on purpose. The first is a start and a done strobe in the same core cycle. The second is a done strobe raised exactly in the cycle that carries the final enable pulse, found by waiting for `sd_clk_en` and asserting done at that point. A behavioural model run on every clock predicts start-over-done and done-over-expiry. The event counts after each case are compared with it, along with every cycle of `sd_clk`, `sd_clk_en` and `tmo_event`. Divisor changes in the middle of a period are also checked against the model, which reloads its ratio only at the period boundary.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_RUN   = 2'd1,
        TM_FIRED = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel #(
    parameter int DIV_W  = 11,
    parameter int FAST_W = 3
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             slow_card,
    input  logic             data_mode,
    output logic [DIV_W:0]   ratio
);
    localparam logic [DIV_W:0] OFFSET = (DIV_W+1)'(2);

    logic [DIV_W-1:0] eff;

    generate
        if (FAST_W >= DIV_W) begin : g_full
            assign eff = div_val;
        end else begin : g_trunc
            always_comb begin
                eff = div_val;
                if (data_mode && !slow_card) begin
                    eff = {{(DIV_W-FAST_W){1'b0}}, div_val[FAST_W-1:0]};
                end
            end
        end
    endgenerate

    assign ratio = {1'b0, eff} + OFFSET;

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIV_W:0] next_ratio,
    output logic           sd_clk,
    output logic           sd_clk_en
);
    localparam logic [DIV_W:0] ONE_R     = (DIV_W+1)'(1);
    localparam logic [DIV_W:0] RST_RATIO = (DIV_W+1)'((1 << DIV_W) + 1);

    function automatic logic [DIV_W-1:0] high_last(input logic [DIV_W:0] r);
        logic [DIV_W:0] h;
        h = (r + ONE_R) >> 1;
        return DIV_W'(h - ONE_R);
    endfunction

    function automatic logic [DIV_W-1:0] low_last(input logic [DIV_W:0] r);
        logic [DIV_W:0] l;
        l = r >> 1;
        return DIV_W'(l - ONE_R);
    endfunction

    phase_e           phase, phase_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic [DIV_W:0]   ratio_q, ratio_n;
    logic             wrap;
    logic             en_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_HIGH;
            cnt     <= high_last(RST_RATIO);
            ratio_q <= RST_RATIO;
        end else begin
            phase   <= phase_n;
            cnt     <= cnt_n;
            ratio_q <= ratio_n;
        end
    end

    // next-state logic: HIGH_TO_LOW and LOW_TO_HIGH transitions
    always_comb begin
        phase_n = phase;
        cnt_n   = cnt - 1'b1;
        ratio_n = ratio_q;
        wrap    = 1'b0;
        if (cnt == '0) begin
            unique case (phase)
                PH_HIGH: begin
                    phase_n = PH_LOW;
                    cnt_n   = low_last(ratio_q);
                end
                PH_LOW: begin
                    phase_n = PH_HIGH;
                    ratio_n = next_ratio;
                    cnt_n   = high_last(next_ratio);
                    wrap    = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= wrap;
        end
    end

    assign sd_clk    = (phase == PH_HIGH);
    assign sd_clk_en = en_q;

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_clk_en |=> !sd_clk_en); // R6

    AST_EN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_clk_en |-> (phase == PH_HIGH) && ($past(phase) == PH_LOW)); // R6

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW || $past(phase) == PH_HIGH) |-> $stable(ratio_q)); // R4

endmodule

// File: rtl/sdclk_timeout.sv
module sdclk_timeout
    import sdclk_pkg::*;
#(
    parameter int          TMO_W   = 32,
    parameter logic [31:0] TMO_RST = 32'h00F0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             done,
    input  logic [TMO_W-1:0] start_val,
    output logic             tmo_event
);
    localparam logic [TMO_W-1:0] ONE_T = TMO_W'(1);

    tmr_state_e       state, state_n;
    logic [TMO_W-1:0] cnt, cnt_n;
    logic             fire;
    logic             evt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TM_IDLE;
            cnt   <= TMO_W'(TMO_RST);
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // ARM / REARM have priority over DISARM, which has priority over EXPIRE
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        fire    = 1'b0;
        if (start) begin
            state_n = TM_RUN;
            cnt_n   = start_val;
        end else if (done) begin
            if (state == TM_RUN) begin
                state_n = TM_IDLE;
            end
        end else begin
            unique case (state)
                TM_RUN: begin
                    if (tick) begin
                        if (cnt <= ONE_T) begin
                            state_n = TM_FIRED;
                            cnt_n   = '0;
                            fire    = 1'b1;
                        end else begin
                            cnt_n = cnt - ONE_T;
                        end
                    end
                end
                TM_IDLE, TM_FIRED: begin
                    state_n = state;
                end
                default: begin
                    state_n = TM_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= fire;
        end
    end

    assign tmo_event = evt_q;

    AST_EVT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_event |=> !tmo_event); // R7

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == TM_RUN) && (cnt == $past(start_val))); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !tmo_event); // R8

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int          DIV_W   = 11,
    parameter int          FAST_W  = 3,
    parameter int          TMO_W   = 32,
    parameter logic [31:0] TMO_RST = 32'h00F0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             slow_card,
    input  logic             data_mode,
    input  logic [TMO_W-1:0] tmo_start_val,
    input  logic             tmo_start,
    input  logic             tmo_done,
    output logic             sd_clk,
    output logic             sd_clk_en,
    output logic             tmo_event
);
    logic [DIV_W:0] next_ratio;
    logic           en_int;

    sdclk_ratio_sel #(.DIV_W(DIV_W), .FAST_W(FAST_W)) u_sel (
        .div_val   (div_val),
        .slow_card (slow_card),
        .data_mode (data_mode),
        .ratio     (next_ratio)
    );

    sdclk_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_ratio (next_ratio),
        .sd_clk     (sd_clk),
        .sd_clk_en  (en_int)
    );

    sdclk_timeout #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (en_int),
        .start     (tmo_start),
        .done      (tmo_done),
        .start_val (tmo_start_val),
        .tmo_event (tmo_event)
    );

    assign sd_clk_en = en_int;

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] div_val = 11'h7FF;
    logic        slow_card = 1'b1;
    logic        data_mode = 1'b0;
    logic [31:0] tmo_start_val = 32'd0;
    logic        tmo_start = 1'b0;
    logic        tmo_done = 1'b0;
    logic        sd_clk, sd_clk_en, tmo_event;

    int    n_tests = 0;
    int    n_fail = 0;
    int    ev_cnt = 0;
    int    cycles = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R3";

    // reference model state
    int     m_ratio = 2049;
    int     m_pos = 0;
    bit     m_en = 1'b0;
    bit     m_run = 1'b0;
    bit     m_evt = 1'b0;
    longint m_cnt = 0;

    always #5 clk = ~clk;

    sdclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .slow_card(slow_card),
        .data_mode(data_mode), .tmo_start_val(tmo_start_val), .tmo_start(tmo_start),
        .tmo_done(tmo_done), .sd_clk(sd_clk), .sd_clk_en(sd_clk_en), .tmo_event(tmo_event)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input int val);
        tmo_start_val = val;
        tmo_start = 1'b1;
        @(negedge clk);
        tmo_start = 1'b0;
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ratio = 2049; m_pos = 0; m_en = 0; m_run = 0; m_evt = 0;
        end else begin
            bit nevt;
            int eff;
            nevt = 0;
            if (tmo_start) begin
                m_run = 1; m_cnt = tmo_start_val;
            end else if (tmo_done) begin
                m_run = 0;
            end else if (m_run && m_en) begin
                if (m_cnt <= 1) begin m_run = 0; nevt = 1; end
                else m_cnt = m_cnt - 1;
            end
            m_evt = nevt;
            if (m_pos == m_ratio - 1) begin
                eff = (data_mode && !slow_card) ? (int'(div_val) % 8) : int'(div_val);
                m_ratio = eff + 2;
                m_pos = 0;
                m_en = 1;
            end else begin
                m_pos++;
                m_en = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            check(cur_req, "sd_clk", sd_clk, (m_pos < (m_ratio + 1) / 2));
            check(cur_req, "sd_clk_en", sd_clk_en, m_en);
            check(cur_req, "tmo_event", tmo_event, m_evt);
        end
        if (tmo_event === 1'b1) ev_cnt++;
    end

    initial begin
        while (!finished) begin
            @(posedge clk);
            if (cycles > 200000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int e0;
        // R3: reset state
        wait_cycles(3);
        check("R3", "sd_clk in reset", sd_clk, 1'b1);
        check("R3", "sd_clk_en in reset", sd_clk_en, 1'b0);
        check("R3", "tmo_event in reset", tmo_event, 1'b0);
        rst_n = 1'b1;
        checking = 1'b1;
        cur_req = "R3";
        wait_cycles(10);

        // R4: change mid-period; the 2049-cycle first period must still run
        cur_req = "R4";
        div_val = 11'd5;
        wait_cycles(2100);

        // R1 and R2: odd, minimum and even ratios
        cur_req = "R2";
        wait_cycles(30);
        cur_req = "R1";
        div_val = 11'd0;
        wait_cycles(20);
        cur_req = "R2";
        div_val = 11'd1;
        wait_cycles(24);
        cur_req = "R4";
        div_val = 11'd6;
        wait_cycles(3);
        div_val = 11'd2;
        wait_cycles(30);

        // R5: data-mode truncation and the slow-card override
        cur_req = "R5";
        data_mode = 1'b1; slow_card = 1'b0; div_val = 11'h00A;
        wait_cycles(40);
        slow_card = 1'b1;
        wait_cycles(60);
        slow_card = 1'b0; div_val = 11'h7FB;
        wait_cycles(40);
        data_mode = 1'b0; div_val = 11'd2;
        wait_cycles(30);

        // R6: one enable per 4-cycle period
        cur_req = "R6";
        while (sd_clk_en !== 1'b1) @(negedge clk);
        e0 = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sd_clk_en === 1'b1) e0++;
        end
        check_int("R6", "enable pulses in 40 cycles", e0, 10);

        // R7: single event after expiry
        cur_req = "R7";
        e0 = ev_cnt;
        pulse_start(3);
        wait_cycles(40);
        check_int("R7", "events after start of 3", ev_cnt - e0, 1);

        // R8: done stops the count
        cur_req = "R8";
        e0 = ev_cnt;
        pulse_start(5);
        wait_cycles(8);
        tmo_done = 1'b1;
        @(negedge clk);
        tmo_done = 1'b0;
        wait_cycles(40);
        check_int("R8", "events after done", ev_cnt - e0, 0);

        // R9: start and done together -> start wins
        cur_req = "R9";
        e0 = ev_cnt;
        tmo_start_val = 2; tmo_start = 1'b1; tmo_done = 1'b1;
        @(negedge clk);
        tmo_start = 1'b0; tmo_done = 1'b0;
        wait_cycles(30);
        check_int("R9", "events after start+done", ev_cnt - e0, 1);

        // R9: done on the final enable -> no event
        e0 = ev_cnt;
        pulse_start(1);
        while (sd_clk_en !== 1'b1) @(negedge clk);
        tmo_done = 1'b1;
        @(negedge clk);
        tmo_done = 1'b0;
        wait_cycles(20);
        check_int("R9", "events when done meets expiry", ev_cnt - e0, 0);

        // R10: restart while running and after firing
        cur_req = "R10";
        e0 = ev_cnt;
        pulse_start(6);
        wait_cycles(10);
        check_int("R10", "no early event before restart", ev_cnt - e0, 0);
        pulse_start(6);
        wait_cycles(60);
        check_int("R10", "events after restart", ev_cnt - e0, 1);
        pulse_start(2);
        wait_cycles(30);
        check_int("R10", "events after rearm", ev_cnt - e0, 2);

        checking = 1'b0;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule